// File: doc/BRIEF.md
# Flash Cache Control Register

This block is one 32-bit control word for a flash read path. Software reaches it over a plain register bus with an address, a write enable, write data and combinational read data. The word holds three configuration fields: a cache-off switch, a prefetch-off switch and a two-bit sleep policy. It also holds three request bits that software can only set and that hardware clears.

The block turns the configuration into a single effective prefetch enable, with the cache-off switch overriding the prefetch switch. The cache-invalidate request produces a one-cycle strobe toward the cache once no flash read is in flight, and then drops. The two mode-toggle requests, one for temperature read mode and one for low-power mode, stay raised toward the flash controller until the matching status input changes level. The block detects that change against a copy of the status input from the previous cycle. Flash timing, wait states and the cache array lie outside this block.

Top module: `fcache_ctl_reg`

## Requirements
- R1: After reset the word at byte offset 0x4 reads 0x00000000, `prefetch_en` is 1, and `cache_disable`, `sleep_policy`, `cache_inval_stb` and both toggle requests are 0.
- R2: A write to offset 0x4 stores bit 17 (prefetch off), bit 16 (cache off) and bits 9:8 (sleep policy: 0 manual, 2 auto-fast, 3 auto-slow, 1 reserved but stored). These appear on `cache_disable` and `sleep_policy` and read back in the same positions. Bits 31:18, 15:10, 6:2 always read 0.
- R3: `prefetch_en` is 1 only when both bit 16 and bit 17 are 0. When bit 16 is 1, bit 17 has no effect on it.
- R4: Writing 1 to bit 0 raises `power_toggle_req` (read back at bit 0) from the next cycle. It holds until `power_mode_status` differs from its value in the previous cycle, and it is 0 from the cycle after that change.
- R5: Bit 1 and `temp_toggle_req` behave as in R4, keyed to `temp_mode_status`.
- R6: Writing 0 to bit 0, bit 1 or bit 7 never clears or sets the request.
- R7: Writing 1 to bit 7 sets the invalidate request (read back at bit 7). While it is set and `flash_read_busy` is 0, `cache_inval_stb` is 1 for exactly one cycle, and the request reads 0 afterward.
- R8: While `flash_read_busy` is 1, `cache_inval_stb` stays 0 and a pending invalidate request is kept. The strobe appears in the first cycle with `flash_read_busy` low.
- R9: When a write setting a request bit falls in the same cycle as that request's hardware clear, the request stays 1.
- R10: Writes to any other offset change nothing, and reads of any other offset return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write enable for this cycle |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| flash_read_busy | input | 1 | A flash read is in progress |
| temp_mode_status | input | 1 | Current temperature read mode level |
| power_mode_status | input | 1 | Current flash power mode level |
| prefetch_en | output | 1 | Effective predictive prefetch enable |
| cache_disable | output | 1 | Cache-off field |
| sleep_policy | output | 2 | Sleep policy field |
| cache_inval_stb | output | 1 | One-cycle cache invalidate strobe |
| temp_toggle_req | output | 1 | Pending temperature-mode toggle request |
| power_toggle_req | output | 1 | Pending power-mode toggle request |

## Verification
The software set of a request bit and its hardware clear can land on the same clock edge. For the toggle bits, the bench drives a write of 1 in the same cycle that it flips the status input, and then expects the request still raised one cycle later. For invalidate, it writes bit 7 again in the very cycle the strobe is out, and expects a second strobe in the next cycle followed by a clear. The cases where software wins are judged apart from the ordinary clear paths, which are exercised in their own tests.

// File: rtl/fcc_pkg.sv
package fcc_pkg;

   // How a request bit is retired once software has raised it
   typedef enum logic [0:0] {
      CLR_ON_STATUS = 1'b0,  // retired when a status level changes
      CLR_ON_ISSUE  = 1'b1   // retired once its strobe has gone out
   } clr_kind_e;

   // Sleep policy encodings
   typedef enum logic [1:0] {
      SLP_MANUAL    = 2'd0,
      SLP_RESERVED  = 2'd1,
      SLP_AUTO_FAST = 2'd2,
      SLP_AUTO_SLOW = 2'd3
   } sleep_pol_e;

   // Field positions inside the control word
   localparam int unsigned POS_PWR_TGL  = 0;
   localparam int unsigned POS_TEMP_TGL = 1;
   localparam int unsigned POS_INVAL    = 7;
   localparam int unsigned POS_SLEEP_LO = 8;
   localparam int unsigned POS_SLEEP_HI = 9;
   localparam int unsigned POS_CACHE_OFF = 16;
   localparam int unsigned POS_PF_OFF   = 17;
   localparam int unsigned MIN_WORD_W   = POS_PF_OFF + 1;

   typedef struct packed {
      logic       pf_off;
      logic       cache_off;
      logic [1:0] sleep;
   } cfg_t;

endpackage

// File: rtl/fcc_req_cell.sv
module fcc_req_cell
   import fcc_pkg::*;
#(
   parameter clr_kind_e KIND = CLR_ON_STATUS
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,   // software writes 1
   input  logic ev_i,    // status level (CLR_ON_STATUS) or busy (CLR_ON_ISSUE)
   output logic req_o
);

   logic req_q;
   logic done;

   generate
      if (KIND == CLR_ON_STATUS) begin : g_status
         // Shadow samples every cycle, reset included, so a level held
         // through reset is never seen as a change.
         logic ev_q;
         always_ff @(posedge clk) begin
            ev_q <= ev_i;
         end
         assign done = ev_i ^ ev_q;
      end else begin : g_issue
         // Strobe leaves whenever the path is not busy
         assign done = ~ev_i;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q <= 1'b0;
      end else if (set_i) begin
         req_q <= 1'b1;          // software set wins over the clear
      end else if (done) begin
         req_q <= 1'b0;
      end
   end

   assign req_o = req_q;

endmodule

// File: rtl/fcc_cfg_fields.sv
module fcc_cfg_fields
   import fcc_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic wr_hit,
   input  cfg_t wr_cfg,
   output cfg_t cfg_o,
   output logic prefetch_en_o
);

   cfg_t cfg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (wr_hit) begin
         cfg_q <= wr_cfg;
      end
   end

   assign cfg_o         = cfg_q;
   // cache off forces prefetch off regardless of the prefetch field
   assign prefetch_en_o = ~cfg_q.cache_off & ~cfg_q.pf_off;

endmodule

// File: rtl/fcc_readback.sv
module fcc_readback
   import fcc_pkg::*;
#(
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned REG_OFFSET = 4
) (
   input  logic [ADDR_W-1:0] addr,
   input  cfg_t              cfg,
   input  logic              inval_req,
   input  logic              temp_req,
   input  logic              pwr_req,
   output logic [DATA_W-1:0] rdata
);

   localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(REG_OFFSET);

   logic [DATA_W-1:0] word;

   always_comb begin
      word                              = '0;
      word[POS_PF_OFF]                  = cfg.pf_off;
      word[POS_CACHE_OFF]               = cfg.cache_off;
      word[POS_SLEEP_HI:POS_SLEEP_LO]   = cfg.sleep;
      word[POS_INVAL]                   = inval_req;
      word[POS_TEMP_TGL]                = temp_req;
      word[POS_PWR_TGL]                 = pwr_req;
   end

   assign rdata = (addr == HIT_ADDR) ? word : '0;

endmodule

// File: rtl/fcache_ctl_reg.sv
module fcache_ctl_reg
   import fcc_pkg::*;
#(
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned REG_OFFSET = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              flash_read_busy,
   input  logic              temp_mode_status,
   input  logic              power_mode_status,
   output logic              prefetch_en,
   output logic              cache_disable,
   output logic [1:0]        sleep_policy,
   output logic              cache_inval_stb,
   output logic              temp_toggle_req,
   output logic              power_toggle_req
);

   localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(REG_OFFSET);
   localparam int unsigned       N_REQ    = 3;

   // Elaboration-time parameter checks
   generate
      if (DATA_W < MIN_WORD_W) begin : g_bad_width
         $error("fcache_ctl_reg: DATA_W too narrow for the field layout");
      end
      if ((REG_OFFSET % 4) != 0) begin : g_bad_align
         $error("fcache_ctl_reg: REG_OFFSET must be word aligned");
      end
      if (REG_OFFSET >= (64'd1 << ADDR_W)) begin : g_bad_offset
         $error("fcache_ctl_reg: REG_OFFSET outside the address range");
      end
   endgenerate

   logic wr_hit;
   cfg_t wr_cfg;
   cfg_t cfg;
   logic unused_wdata;

   assign wr_hit       = bus_wr && (bus_addr == HIT_ADDR);
   assign wr_cfg       = '{pf_off:    bus_wdata[POS_PF_OFF],
                           cache_off: bus_wdata[POS_CACHE_OFF],
                           sleep:     bus_wdata[POS_SLEEP_HI:POS_SLEEP_LO]};
   assign unused_wdata = ^bus_wdata;

   fcc_cfg_fields u_cfg (
      .clk           (clk),
      .rst_n         (rst_n),
      .wr_hit        (wr_hit),
      .wr_cfg        (wr_cfg),
      .cfg_o         (cfg),
      .prefetch_en_o (prefetch_en)
   );

   // Request cells: index 0 power, 1 temperature, 2 invalidate
   logic [N_REQ-1:0] req_set;
   logic [N_REQ-1:0] req_ev;
   logic [N_REQ-1:0] req_q;

   assign req_set[0] = wr_hit & bus_wdata[POS_PWR_TGL];
   assign req_set[1] = wr_hit & bus_wdata[POS_TEMP_TGL];
   assign req_set[2] = wr_hit & bus_wdata[POS_INVAL];
   assign req_ev     = {flash_read_busy, temp_mode_status, power_mode_status};

   generate
      for (genvar gi = 0; gi < N_REQ; gi++) begin : g_req
         localparam clr_kind_e KIND = (gi == N_REQ - 1) ? CLR_ON_ISSUE : CLR_ON_STATUS;
         fcc_req_cell #(.KIND(KIND)) u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (req_set[gi]),
            .ev_i  (req_ev[gi]),
            .req_o (req_q[gi])
         );
      end
   endgenerate

   assign power_toggle_req = req_q[0];
   assign temp_toggle_req  = req_q[1];
   assign cache_inval_stb  = req_q[2] & ~flash_read_busy;
   assign cache_disable    = cfg.cache_off;
   assign sleep_policy     = cfg.sleep;

   fcc_readback #(
      .ADDR_W     (ADDR_W),
      .DATA_W     (DATA_W),
      .REG_OFFSET (REG_OFFSET)
   ) u_rb (
      .addr      (bus_addr),
      .cfg       (cfg),
      .inval_req (req_q[2]),
      .temp_req  (req_q[1]),
      .pwr_req   (req_q[0]),
      .rdata     (bus_rdata)
   );

endmodule

// File: rtl/fcc_ctl_checker.sv
module fcc_ctl_checker #(
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned REG_OFFSET = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              flash_read_busy,
   input logic              temp_mode_status,
   input logic              power_mode_status,
   input logic              prefetch_en,
   input logic              cache_disable,
   input logic              cache_inval_stb,
   input logic              temp_toggle_req,
   input logic              power_toggle_req
);

   logic hit;
   assign hit = bus_wr && (bus_addr == ADDR_W'(REG_OFFSET));

   // R3: cache off forces prefetch off
   a_r3_cache_off_kills_prefetch: assert property (@(posedge clk) disable iff (!rst_n)
      cache_disable |-> !prefetch_en);

   // R4: power request held while status is steady
   a_r4_pwr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      power_toggle_req && $stable(power_mode_status) |=> power_toggle_req);

   // R4: power request dropped after a status change without a new set
   a_r4_pwr_clear: assert property (@(posedge clk) disable iff (!rst_n)
      power_toggle_req && !$stable(power_mode_status) && !(hit && bus_wdata[0])
      |=> !power_toggle_req);

   // R5: temperature request held while status is steady
   a_r5_temp_hold: assert property (@(posedge clk) disable iff (!rst_n)
      temp_toggle_req && $stable(temp_mode_status) |=> temp_toggle_req);

   // R7: strobe lasts a single cycle unless re-armed
   a_r7_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      cache_inval_stb && !(hit && bus_wdata[7]) |=> !cache_inval_stb);

   // R8: no strobe during a flash read
   a_r8_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      flash_read_busy |-> !cache_inval_stb);

   // R9: software set always lands
   a_r9_set_wins_pwr: assert property (@(posedge clk) disable iff (!rst_n)
      hit && bus_wdata[0] |=> power_toggle_req);

   a_r9_set_wins_temp: assert property (@(posedge clk) disable iff (!rst_n)
      hit && bus_wdata[1] |=> temp_toggle_req);

endmodule

bind fcache_ctl_reg fcc_ctl_checker #(
   .ADDR_W     (ADDR_W),
   .DATA_W     (DATA_W),
   .REG_OFFSET (REG_OFFSET)
) u_chk (
   .clk               (clk),
   .rst_n             (rst_n),
   .bus_addr          (bus_addr),
   .bus_wr            (bus_wr),
   .bus_wdata         (bus_wdata),
   .flash_read_busy   (flash_read_busy),
   .temp_mode_status  (temp_mode_status),
   .power_mode_status (power_mode_status),
   .prefetch_en       (prefetch_en),
   .cache_disable     (cache_disable),
   .cache_inval_stb   (cache_inval_stb),
   .temp_toggle_req   (temp_toggle_req),
   .power_toggle_req  (power_toggle_req)
);

// File: tb/fcache_ctl_reg_bench.sv
module fcache_ctl_reg_bench;

   localparam int unsigned AW  = 8;
   localparam int unsigned DW  = 32;
   localparam logic [AW-1:0] OFS = 8'h04;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] bus_addr = OFS;
   logic          bus_wr = 1'b0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic          flash_read_busy = 1'b0;
   logic          temp_mode_status = 1'b0;
   logic          power_mode_status = 1'b1;
   logic          prefetch_en;
   logic          cache_disable;
   logic [1:0]    sleep_policy;
   logic          cache_inval_stb;
   logic          temp_toggle_req;
   logic          power_toggle_req;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;  // 50 MHz

   fcache_ctl_reg #(.ADDR_W(AW), .DATA_W(DW), .REG_OFFSET(4)) u_fcache_ctl_reg (
      .clk               (clk),
      .rst_n             (rst_n),
      .bus_addr          (bus_addr),
      .bus_wr            (bus_wr),
      .bus_wdata         (bus_wdata),
      .bus_rdata         (bus_rdata),
      .flash_read_busy   (flash_read_busy),
      .temp_mode_status  (temp_mode_status),
      .power_mode_status (power_mode_status),
      .prefetch_en       (prefetch_en),
      .cache_disable     (cache_disable),
      .sleep_policy      (sleep_policy),
      .cache_inval_stb   (cache_inval_stb),
      .temp_toggle_req   (temp_toggle_req),
      .power_toggle_req  (power_toggle_req)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   // Drive a write for one cycle; returns at the next falling edge
   task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
      bus_addr  = a;
      bus_wdata = d;
      bus_wr    = 1'b1;
      @(negedge clk);
      bus_wr    = 1'b0;
      bus_addr  = OFS;
      bus_wdata = '0;
      #1;
   endtask

   function automatic logic [31:0] rd_at(input logic [AW-1:0] a);
      return bus_rdata;  // bus_addr already set by caller
   endfunction

   task automatic read_chk(input string req, input logic [AW-1:0] a, input logic [31:0] exp);
      bus_addr = a;
      #1;
      chk(req, rd_at(a), exp);
      bus_addr = OFS;
      #1;
   endtask

   task automatic t_reset;
      read_chk("R1 word", OFS, 32'h0);
      chk("R1 prefetch_en", 32'(prefetch_en), 32'd1);
      chk("R1 outputs", {27'd0, cache_disable, sleep_policy, cache_inval_stb,
                         temp_toggle_req, power_toggle_req}, 32'd0);
   endtask

   task automatic t_fields;
      bus_write(OFS, 32'hFFFF_FF7C);
      read_chk("R2 readback all ones", OFS, 32'h0003_0300);
      chk("R2 cache_disable", 32'(cache_disable), 32'd1);
      chk("R2 sleep auto-slow", 32'(sleep_policy), 32'd3);
      bus_write(OFS, 32'h0000_0100);
      read_chk("R2 reserved sleep stored", OFS, 32'h0000_0100);
      chk("R2 sleep reserved", 32'(sleep_policy), 32'd1);
   endtask

   task automatic t_prefetch;
      bus_write(OFS, 32'h0000_0000);
      chk("R3 both on", 32'(prefetch_en), 32'd1);
      bus_write(OFS, 32'h0002_0200);
      chk("R3 prefetch off", 32'(prefetch_en), 32'd0);
      chk("R2 sleep auto-fast", 32'(sleep_policy), 32'd2);
      bus_write(OFS, 32'h0001_0000);
      chk("R3 cache off overrides", 32'(prefetch_en), 32'd0);
      bus_write(OFS, 32'h0003_0000);
      chk("R3 both off", 32'(prefetch_en), 32'd0);
      bus_write(OFS, 32'h0000_0000);
   endtask

   task automatic t_pwr_toggle;
      bus_write(OFS, 32'h0000_0001);
      chk("R4 raised", 32'(power_toggle_req), 32'd1);
      repeat (4) @(negedge clk);
      read_chk("R4 held", OFS, 32'h0000_0001);
      power_mode_status = ~power_mode_status;
      #1;
      chk("R4 still set in change cycle", 32'(power_toggle_req), 32'd1);
      @(negedge clk);
      chk("R4 cleared after change", 32'(power_toggle_req), 32'd0);
      read_chk("R4 readback cleared", OFS, 32'h0);
   endtask

   task automatic t_temp_toggle;
      bus_write(OFS, 32'h0000_0002);
      chk("R5 raised", 32'(temp_toggle_req), 32'd1);
      power_mode_status = ~power_mode_status;  // other status must not clear it
      repeat (3) @(negedge clk);
      read_chk("R5 held", OFS, 32'h0000_0002);
      temp_mode_status = ~temp_mode_status;
      @(negedge clk);
      chk("R5 cleared after change", 32'(temp_toggle_req), 32'd0);
   endtask

   task automatic t_zero_write;
      bus_write(OFS, 32'h0000_0003);
      bus_write(OFS, 32'h0000_0000);
      read_chk("R6 zero write keeps requests", OFS, 32'h0000_0003);
      power_mode_status = ~power_mode_status;
      temp_mode_status  = ~temp_mode_status;
      @(negedge clk);
      bus_write(OFS, 32'h0000_0000);
      read_chk("R6 zero write does not set", OFS, 32'h0);
      chk("R6 no strobe", 32'(cache_inval_stb), 32'd0);
   endtask

   task automatic t_inval;
      bus_write(OFS, 32'h0000_0080);
      chk("R7 strobe", 32'(cache_inval_stb), 32'd1);
      @(negedge clk);
      chk("R7 strobe one cycle", 32'(cache_inval_stb), 32'd0);
      read_chk("R7 request cleared", OFS, 32'h0);
   endtask

   task automatic t_inval_busy;
      flash_read_busy = 1'b1;
      bus_write(OFS, 32'h0000_0080);
      chk("R8 no strobe while busy", 32'(cache_inval_stb), 32'd0);
      repeat (3) @(negedge clk);
      read_chk("R8 request kept", OFS, 32'h0000_0080);
      flash_read_busy = 1'b0;
      #1;
      chk("R8 strobe when idle", 32'(cache_inval_stb), 32'd1);
      @(negedge clk);
      chk("R8 strobe done", 32'(cache_inval_stb), 32'd0);
      read_chk("R8 cleared", OFS, 32'h0);
   endtask

   task automatic t_collision;
      bus_write(OFS, 32'h0000_0001);
      // flip status and set again in the same cycle
      power_mode_status = ~power_mode_status;
      bus_write(OFS, 32'h0000_0001);
      chk("R9 power set wins", 32'(power_toggle_req), 32'd1);
      @(negedge clk);
      chk("R9 power still set", 32'(power_toggle_req), 32'd1);
      power_mode_status = ~power_mode_status;
      @(negedge clk);
      chk("R9 power later cleared", 32'(power_toggle_req), 32'd0);
      bus_write(OFS, 32'h0000_0080);
      chk("R9 first strobe", 32'(cache_inval_stb), 32'd1);
      bus_write(OFS, 32'h0000_0080);
      chk("R9 second strobe", 32'(cache_inval_stb), 32'd1);
      @(negedge clk);
      chk("R9 strobe ends", 32'(cache_inval_stb), 32'd0);
   endtask

   task automatic t_other_offset;
      bus_write(8'h08, 32'hFFFF_FFFF);
      bus_write(8'h00, 32'hFFFF_FFFF);
      read_chk("R10 word untouched", OFS, 32'h0);
      read_chk("R10 other offset reads zero", 8'h08, 32'h0);
      chk("R10 no requests", {29'd0, cache_inval_stb, temp_toggle_req, power_toggle_req}, 32'd0);
      chk("R10 prefetch unchanged", 32'(prefetch_en), 32'd1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_fields();
      t_prefetch();
      t_pwr_toggle();
      t_temp_toggle();
      t_zero_write();
      t_inval();
      t_inval_busy();
      t_collision();
      t_other_offset();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

endmodule